// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Writes

A single-port synchronous memory of 32-bit words. Its depth is set by a parameter, and it is meant to serve as a fast local store behind a cache or a processor bus. All control, address and write data are taken on the rising clock edge.

An access is opened by one of two start strobes. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write controls. Once a burst is open, both strobes are held high. An advance input then either steps the two low address bits to the next beat or holds the current beat. The step follows a linear or an interleaved order, chosen by a mode input.

Writes cover any subset of the four byte lanes. Read data leaves through an output register one clock after the address is taken. An output-enable input gates the drive without waiting for a clock. The bus is modelled as separate data-in and data-out ports, plus a drive flag.

A sleep input puts the memory into power-down. After sleep is released, the memory refuses access for a fixed three-cycle wake-up window.

Top module: `burst_sram`

## Requirements
- R1: After reset, `dout_en` is low and stays low until a read has been completed.
- R2: The word at the address of a read access appears on `dout`, with `dout_en` high when `oe_n` is low, after the next rising edge. The data is sampled one full clock after the access edge.
- R3: With `gwr_n` low on a write-capable access, all four byte lanes are written, whatever `bwr_n` and `lane_n` hold.
- R4: With `gwr_n` high and `bwr_n` low, each lane whose `lane_n` bit is low is written: bit 0 covers data bits 7:0, bit 1 covers 15:8, bit 2 covers 23:16 and bit 3 covers 31:24. The other lanes keep their contents.
- R5: With `gwr_n` high and `bwr_n` high, or with `bwr_n` low and all of `lane_n` high, nothing is written and the access is a read.
- R6: With `mode_lin` = 1, beat k of a burst uses low address bits (start + k) mod 4. The upper address bits stay fixed.
- R7: With `mode_lin` = 0, beat k of a burst uses low address bits start XOR k.
- R8: While a burst is open (both strobes high), `adv_n` low moves to the next beat and `adv_n` high repeats the current address, so the read data is held.
- R9: A start on `pstb_n` (low, with `sel_n` low) is a read whatever the write controls say. A write to that address is made on the following edge, with both strobes high, `adv_n` high and a write control active.
- R10: `dout_en` is low while `oe_n` is high, and it follows `oe_n` without waiting for a clock. It is also low in the cycle after a write access and after a deselect (a strobe low with `sel_n` high).
- R11: While `sleep` is high, `dout_en` is low from the next edge on and no access takes place. After `sleep` falls, the first three rising edges are still refused. Accesses in the sleep or wake window leave memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Device select, active low, taken with a start strobe |
| pstb_n | input | 1 | Processor start strobe, active low, always reads |
| cstb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high holds the beat |
| mode_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | $clog2(DEPTH) | Word address taken on a start |
| gwr_n | input | 1 | Global write, active low, all lanes |
| bwr_n | input | 1 | Byte-write enable, active low |
| lane_n | input | 4 | Per-lane write enables, active low |
| din | input | 32 | Write data |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Power-down request, active high |
| dout | output | 32 | Registered read data |
| dout_en | output | 1 | High when `dout` would be driven onto the bus |

## Verification
The hardest case to reach from the ports is the wake-up window. A write has to be attempted on exactly each of the three refused edges, and then on the first edge that is accepted. The stimulus therefore lowers `sleep` on a falling edge and issues a controller-strobe write on each of the next four falling edges. Reads afterwards show that only the fourth write landed. The processor-strobe case is also timing-sensitive: the forced read and the write that follows on the next edge target the same address. The bench checks that the old word comes out while the new one lands.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int WORD_W   = 32;
    localparam int LANE_W   = 8;
    localparam int LANES    = WORD_W / LANE_W;
    localparam int WAKE_CYC = 3;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [LANES-1:0] mask;
    } acc_t;

    // Low two address bits of a beat: linear adds, interleaved flips.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input logic       linear);
        return linear ? (start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/bsr_wake.sv
module bsr_wake
    import bsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sleep,
    output logic awake
);
    localparam int CW = $clog2(WAKE_CYC + 1);

    logic [CW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (sleep)
            hold_q <= CW'(WAKE_CYC);
        else if (hold_q != '0)
            hold_q <= hold_q - 1'b1;
    end

    assign awake = !sleep && (hold_q == '0);

    // R11
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sleep) |-> !awake);

endmodule

// File: rtl/bsr_seq.sv
module bsr_seq
    import bsr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          awake,
    input  logic          sel_n,
    input  logic          pstb_n,
    input  logic          cstb_n,
    input  logic          adv_n,
    input  logic          mode_lin,
    input  logic [AW-1:0] ext_addr,
    output logic          go,
    output logic          force_rd,
    output logic [AW-1:0] acc_addr
);
    logic [AW-1:0] base_q;
    logic [1:0]    beat_q;
    logic          live_q;

    logic start_p, start_c, drop, cont;
    logic [1:0] beat_n;

    always_comb begin
        start_p = !pstb_n && !sel_n;
        start_c = pstb_n && !cstb_n && !sel_n;
        drop    = (!pstb_n || !cstb_n) && sel_n;
        cont    = pstb_n && cstb_n && live_q;
        beat_n  = adv_n ? beat_q : beat_q + 2'd1;
        go       = awake && (start_p || start_c || cont);
        force_rd = start_p;
        if (start_p || start_c)
            acc_addr = ext_addr;
        else
            acc_addr = {base_q[AW-1:2], burst_low(base_q[1:0], beat_n, mode_lin)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            beat_q <= '0;
            live_q <= 1'b0;
        end else if (!awake) begin
            live_q <= 1'b0;
        end else if (start_p || start_c) begin
            base_q <= ext_addr;
            beat_q <= '0;
            live_q <= 1'b1;
        end else if (drop) begin
            live_q <= 1'b0;
        end else if (cont) begin
            beat_q <= beat_n;
        end
    end

    // R8
    suspend_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (cont && adv_n && awake && $past(go) && $stable(mode_lin))
            |-> acc_addr == $past(acc_addr));

endmodule

// File: rtl/bsr_wdec.sv
module bsr_wdec
    import bsr_pkg::*;
(
    input  logic             force_rd,
    input  logic             gwr_n,
    input  logic             bwr_n,
    input  logic [LANES-1:0] lane_n,
    output acc_t             acc
);
    always_comb begin
        if (force_rd)
            acc.mask = '0;
        else if (!gwr_n)
            acc.mask = '1;
        else if (!bwr_n)
            acc.mask = ~lane_n;
        else
            acc.mask = '0;
        acc.kind = (acc.mask != '0) ? ACC_WRITE : ACC_READ;
    end

endmodule

// File: rtl/bsr_array.sv
module bsr_array
    import bsr_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g])
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            if (re)
                rdata[g*LANE_W +: LANE_W] <= cells[raddr];
        end
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsr_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              mode_lin,
    input  logic [AW-1:0]     addr,
    input  logic              gwr_n,
    input  logic              bwr_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic [WORD_W-1:0] din,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);
    logic             awake, go, force_rd;
    logic [AW-1:0]    acc_addr;
    acc_t             acc;
    logic [LANES-1:0] we;
    logic             rd;
    logic             pend_rd_q, drive_q;
    logic [AW-1:0]    pend_addr_q;
    logic [WORD_W-1:0] rdata;

    bsr_wake u_wake (
        .clk   (clk),
        .rst   (rst),
        .sleep (sleep),
        .awake (awake)
    );

    bsr_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .awake    (awake),
        .sel_n    (sel_n),
        .pstb_n   (pstb_n),
        .cstb_n   (cstb_n),
        .adv_n    (adv_n),
        .mode_lin (mode_lin),
        .ext_addr (addr),
        .go       (go),
        .force_rd (force_rd),
        .acc_addr (acc_addr)
    );

    bsr_wdec u_wdec (
        .force_rd (force_rd),
        .gwr_n    (gwr_n),
        .bwr_n    (bwr_n),
        .lane_n   (lane_n),
        .acc      (acc)
    );

    always_comb begin
        we = (go && acc.kind == ACC_WRITE) ? acc.mask : '0;
        rd = go && acc.kind == ACC_READ;
    end

    bsr_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk   (clk),
        .we    (we),
        .waddr (acc_addr),
        .wdata (din),
        .re    (pend_rd_q),
        .raddr (pend_addr_q),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_rd_q   <= 1'b0;
            pend_addr_q <= '0;
            drive_q     <= 1'b0;
        end else begin
            pend_rd_q   <= rd;
            pend_addr_q <= acc_addr;
            drive_q     <= pend_rd_q && !sleep;
        end
    end

    assign dout    = rdata;
    assign dout_en = drive_q && !oe_n;

    // R9
    pstb_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!pstb_n && !sel_n) |-> we == '0);

    // R11
    asleep_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        !awake |-> we == '0);

    // R3
    global_all_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !force_rd && !gwr_n) |-> we == '1);

    // R2
    read_lat_chk: assert property (@(posedge clk) disable iff (rst)
        rd |=> ##1 (drive_q || $past(sleep)));

    // R11
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !drive_q);

endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n, pstb_n, cstb_n, adv_n, mode_lin;
    logic [AW-1:0] addr;
    logic        gwr_n, bwr_n;
    logic [3:0]  lane_n;
    logic [31:0] din;
    logic        oe_n, sleep;
    logic [31:0] dout;
    logic        dout_en;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    burst_sram #(.DEPTH(DEPTH)) u_burst_sram (
        .clk(clk), .rst(rst), .sel_n(sel_n), .pstb_n(pstb_n), .cstb_n(cstb_n),
        .adv_n(adv_n), .mode_lin(mode_lin), .addr(addr), .gwr_n(gwr_n),
        .bwr_n(bwr_n), .lane_n(lane_n), .din(din), .oe_n(oe_n), .sleep(sleep),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Deselect: strobe low with select high ends any burst.
    task automatic idle_in();
        sel_n = 1'b1; pstb_n = 1'b1; cstb_n = 1'b0; adv_n = 1'b1;
        gwr_n = 1'b1; bwr_n = 1'b1; lane_n = 4'hF; din = '0;
    endtask

    task automatic write_word(logic [AW-1:0] a, logic [31:0] d,
                              logic gw, logic bw, logic [3:0] ln);
        @(negedge clk);
        sel_n = 1'b0; pstb_n = 1'b1; cstb_n = 1'b0; adv_n = 1'b1;
        addr = a; din = d; gwr_n = gw; bwr_n = bw; lane_n = ln;
        @(negedge clk);
        idle_in();
    endtask

    task automatic read_check(logic [AW-1:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        sel_n = 1'b0; pstb_n = 1'b1; cstb_n = 1'b0; adv_n = 1'b1;
        addr = a; gwr_n = 1'b1; bwr_n = 1'b1; lane_n = 4'hF;
        @(negedge clk);
        idle_in();
        @(negedge clk);
        check({req, " data"}, dout, exp);
        check({req, " drive"}, {31'd0, dout_en}, 32'd1);
    endtask

    // Start read at a, then three follow beats with the given advance values.
    task automatic burst4(logic [AW-1:0] a, logic lin, logic [2:0] adv_seq,
                          logic [3:0][31:0] exp, string req);
        mode_lin = lin;
        for (int j = 0; j <= 5; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                check(req, dout, exp[j-2]);
                check({req, " drive"}, {31'd0, dout_en}, 32'd1);
            end
            if (j == 0) begin
                sel_n = 1'b0; pstb_n = 1'b1; cstb_n = 1'b0; addr = a;
                gwr_n = 1'b1; bwr_n = 1'b1; lane_n = 4'hF;
            end else if (j <= 3) begin
                pstb_n = 1'b1; cstb_n = 1'b1; adv_n = adv_seq[j-1];
            end else if (j == 4) begin
                idle_in();
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 drive after reset", {31'd0, dout_en}, 32'd0);
    endtask

    task automatic t_global();
        write_word(8'd10, 32'hA5A5_0F0F, 1'b0, 1'b1, 4'hF);
        read_check(8'd10, 32'hA5A5_0F0F, "R3 global write");
        write_word(8'd11, 32'h3C3C_1234, 1'b0, 1'b0, 4'b1110);
        read_check(8'd11, 32'h3C3C_1234, "R3 global overrides lanes");
    endtask

    task automatic t_lanes();
        write_word(8'd12, 32'h1111_1111, 1'b0, 1'b1, 4'hF);
        write_word(8'd12, 32'h2233_4455, 1'b1, 1'b0, 4'b0101);
        read_check(8'd12, 32'h2211_4411, "R4 lanes 1 and 3");
    endtask

    task automatic t_nowrite();
        write_word(8'd12, 32'h0000_0000, 1'b1, 1'b1, 4'h0);
        read_check(8'd12, 32'h2211_4411, "R5 byte-write enable high");
        write_word(8'd12, 32'h0000_0000, 1'b1, 1'b0, 4'hF);
        read_check(8'd12, 32'h2211_4411, "R5 no lane enabled");
    endtask

    task automatic t_bursts();
        for (int i = 0; i < 4; i++)
            write_word(AW'(16 + i), 32'h100 + i, 1'b0, 1'b1, 4'hF);
        burst4(8'd18, 1'b1, 3'b000, {32'h101, 32'h100, 32'h103, 32'h102}, "R6 linear");
        burst4(8'd17, 1'b0, 3'b000, {32'h102, 32'h103, 32'h100, 32'h101}, "R7 interleaved");
        // adv_seq bit k applies to follow beat k+1: advance, hold, advance
        burst4(8'd16, 1'b1, 3'b010, {32'h102, 32'h101, 32'h101, 32'h100}, "R8 suspend");
    endtask

    task automatic t_pstb();
        write_word(8'd20, 32'hCAFE_0001, 1'b0, 1'b1, 4'hF);
        @(negedge clk);
        sel_n = 1'b0; pstb_n = 1'b0; cstb_n = 1'b1; addr = 8'd20;
        gwr_n = 1'b0; din = 32'hDEAD_DEAD;
        @(negedge clk);
        pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1;
        gwr_n = 1'b0; din = 32'hBEEF_0002;
        @(negedge clk);
        check("R9 forced read data", dout, 32'hCAFE_0001);
        idle_in();
        @(negedge clk);
        check("R10 drive after write", {31'd0, dout_en}, 32'd0);
        read_check(8'd20, 32'hBEEF_0002, "R9 following write");
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        @(negedge clk);
        sel_n = 1'b0; pstb_n = 1'b1; cstb_n = 1'b0; addr = 8'd10;
        gwr_n = 1'b1; bwr_n = 1'b1; lane_n = 4'hF;
        @(negedge clk);
        idle_in();
        @(negedge clk);
        check("R10 oe high", {31'd0, dout_en}, 32'd0);
        oe_n = 1'b0;
        #1;
        check("R10 oe falls", {31'd0, dout_en}, 32'd1);
        check("R2 data under oe", dout, 32'hA5A5_0F0F);
        @(negedge clk);
        check("R10 deselected", {31'd0, dout_en}, 32'd0);
    endtask

    task automatic t_sleep();
        @(negedge clk);
        sleep = 1'b1;
        sel_n = 1'b0; pstb_n = 1'b1; cstb_n = 1'b0; addr = 8'd10;
        gwr_n = 1'b0; din = 32'hBAD0_0000;
        @(negedge clk);
        check("R11 drive asleep", {31'd0, dout_en}, 32'd0);
        @(negedge clk);
        sleep = 1'b0;
        addr = 8'd11; din = 32'hBAD1_0000;
        @(negedge clk);
        addr = 8'd12; din = 32'hBAD2_0000;
        @(negedge clk);
        addr = 8'd13; din = 32'hBAD3_0000;
        @(negedge clk);
        addr = 8'd14; din = 32'h5EED_0014;
        @(negedge clk);
        idle_in();
        read_check(8'd10, 32'hA5A5_0F0F, "R11 write asleep ignored");
        read_check(8'd11, 32'h3C3C_1234, "R11 wake edge 1 ignored");
        read_check(8'd12, 32'h2211_4411, "R11 wake edge 2 ignored");
        read_check(8'd14, 32'h5EED_0014, "R11 fourth edge accepted");
    endtask

    initial begin
        idle_in();
        addr = '0; mode_lin = 1'b1; oe_n = 1'b0; sleep = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_global();
        t_lanes();
        t_nowrite();
        t_bursts();
        t_pstb();
        t_oe();
        t_sleep();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule